// File: doc/BRIEF.md
# Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles. A small four-state controller drives a shift-and-add datapath. One register of 2N+1 bits starts with the multiplier in its low half and collects the partial product in its upper half. A bit counter tells the controller when the final multiplier bit is under test.

A one-cycle start pulse in the idle state captures both operands. After that the controller walks through the multiplier bits. A one bit costs an add cycle and then a shift cycle. A zero bit costs a single shift cycle. When the last bit has been shifted, the controller spends one cycle in a completion state that pulses the done flag. It then returns to idle. The product stays on its output until the next accepted start.

The controller states use a plain binary code. The reset input is asserted asynchronously, and its release is synchronised inside the block.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held low, and at the first sample after the reset edge, `done` is 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the unsigned product of the operands captured at the accepted start, as 2N bits.
- R3: `done` is high for exactly one clock cycle per multiplication.
- R4: `done` goes high at the (N + number of one bits in the captured multiplier)-th rising edge after the edge that accepted start. Every add cycle is followed by a shift cycle.
- R5: A start pulse that arrives while a multiplication is in progress is ignored. The running result and its timing are unchanged.
- R6: After `done`, `product` holds its value until the next accepted start.
- R7: The operands are sampled only at the edge that accepts start. Later changes on the operand inputs do not affect the result.
- R8: Full-scale operands (all ones times all ones) give the correct product, including the carry out of each add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start strobe, accepted only when idle |
| mcand | input | N | Multiplicand operand |
| mplier | input | N | Multiplier operand |
| product | output | 2N | Product, valid while done is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with N = 6. At that width it can run all 4096 operand pairs one after another. This covers zero, one and full-scale on both sides, and every one-bit count from 0 to 6. For each pair, a behavioural model in the bench predicts the cycle in which done should rise from the multiplier's popcount, and the value of the product. A subset of the runs injects a stray start and new operand values mid-operation. These runs show that the busy controller ignores them.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shift_add_mul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic m_i,
  input  logic k_i,
  output logic load_o,
  output logic add_o,
  output logic sh_o,
  output logic done_o
);
  mul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    sh_o    = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (m_i) begin
          add_o   = 1'b1;
          state_d = ST_SHIFT;
        end else begin
          sh_o    = 1'b1;
          state_d = k_i ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        sh_o    = 1'b1;
        state_d = k_i ? ST_DONE : ST_TEST;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  add_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_o |=> (sh_o && !add_o));

  // R4
  last_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_o && k_i) |=> done_o);

  // R5
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !load_o);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           add_i,
  input  logic           sh_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           m_o,
  output logic           k_o,
  output logic [2*N-1:0] product_o
);
  localparam int AW = 2 * N + 1;
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [AW-1:0] acc_q, acc_d;
  logic [N-1:0]  mcand_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_en, cnt_en;

  assign acc_en = load_i | add_i | sh_i;
  assign cnt_en = load_i | sh_i;

  always_comb begin
    acc_d = acc_q;
    if (load_i)     acc_d = {{(N+1){1'b0}}, mplier_i};
    else if (add_i) acc_d[2*N:N] = {1'b0, acc_q[2*N-1:N]} + {1'b0, mcand_q};
    else if (sh_i)  acc_d = {1'b0, acc_q[AW-1:1]};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = '0;
    else if (sh_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (acc_en) acc_q   <= acc_d;
      if (load_i) mcand_q <= mcand_i;
      if (cnt_en) cnt_q   <= cnt_d;
    end
  end

  assign m_o       = acc_q[0];
  assign k_o       = (cnt_q == LAST);
  assign product_o = acc_q[2*N-1:0];

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !add_i && !sh_i) |=> $stable(product_o));

  // R4
  fresh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (N > 1 && load_i) |=> !k_o);

  // R7
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  logic rst_int_n;
  logic load, add, sh, m_bit, k_last;

  mul_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mul_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .m_i     (m_bit),
    .k_i     (k_last),
    .load_o  (load),
    .add_o   (add),
    .sh_o    (sh),
    .done_o  (done)
  );

  mul_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .add_i     (add),
    .sh_i      (sh),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .m_o       (m_bit),
    .k_o       (k_last),
    .product_o (product)
  );
endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int MAXV = (1 << N) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic [2*N-1:0] product;
  logic           done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  shift_add_mul #(.N(N)) u_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int b, input bit inject);
    int cyc;
    int exp_cyc;
    longint exp_p;
    logic [2*N-1:0] held;
    exp_p   = longint'(a) * longint'(b);
    exp_cyc = N + $countones(b[N-1:0]) + 1;
    @(negedge clk);
    mcand  = a[N-1:0];
    mplier = b[N-1:0];
    start  = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cyc = 0;
    while (cyc < 64) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 1) begin
        // R7: operand change after capture
        mcand  = ~a[N-1:0];
        mplier = ~b[N-1:0];
      end
      if (inject && cyc == 3) start = 1'b1;  // R5: stray start while busy
      if (inject && cyc == 4) start = 1'b0;
      if (done) break;
    end
    chk("R4 latency", cyc, exp_cyc);
    chk("R2 product", longint'(product), exp_p);
    held = product;
    @(negedge clk);
    chk("R3 done pulse", longint'(done), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 product hold", longint'(product), longint'(held));
    if (inject) chk("R5 R7 busy start ignored", longint'(held), exp_p);
  endtask

  initial begin
    #(CLK_PERIOD*3);
    chk("R1 reset done", longint'(done), 0);
    chk("R1 reset product", longint'(product), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset done", longint'(done), 0);
    chk("R1 post-reset product", longint'(product), 0);
    repeat (3) @(negedge clk);
    // R8: full-scale corner first
    run(MAXV, MAXV, 1'b0);
    run(MAXV, 1, 1'b1);
    run(0, MAXV, 1'b1);
    run(37, 45, 1'b1);
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        run(a, b, ((a + b) % 97) == 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule